// File: doc/BRIEF.md
# Programmable Counter Array

The block is a multi-channel timer. One 16-bit up-counter, the timebase, advances once per tick. Ticks come from the system clock or from rising edges of an external clock input, and pass through a programmable divisor. Every channel watches the same counter. Each channel has a 16-bit compare/capture register, one input line, one output line, an event flag and an output-inversion bit. Each channel runs in one mode of its own:
- capture of the counter on a chosen input edge
- compare-only software timer
- toggle on compare match
- square-wave frequency output
- pulse-width modulation, edge- or center-aligned, at 8, 9, 10, 11 or 16 bits

A kill input forces the PWM channels to their inactive level. The input is one of two, picked by software.

Software reaches the block through a single-cycle write strobe and a combinational read port. Address 0 is timebase control, address 1 is the counter and address 2 is the event flags. Channel n takes addresses 4+2n (configuration) and 5+2n (compare register).

Top module: `pca_top`

## Requirements
- R1: The counter (address 1) adds one per tick while the run bit (control bit 0) is set and wraps from 0xFFFF to 0x0000. It holds its value while run is clear. A write to address 1 loads it.
- R2: The divisor D sits in control bits 15:8, and a tick occurs on every (D+1)-th source event. Control bit 1 selects the source: 0 means every clock, 1 means each rising edge of ext_clk_i. The divisor phase restarts whenever run is clear.
- R3: Channel configuration bits 2:0 set the mode: 0 off, 1 capture, 2 software timer, 3 toggle on match, 4 frequency, 5 PWM. In capture mode, an edge of cex_i selected by configuration bit 3 (rising) or bit 4 (falling) copies the counter into the compare register, which reads back at address 5+2n. The same edge sets the channel flag. An edge that is not selected changes neither.
- R4: In software-timer mode the flag sets when the counter steps onto the compare value. The output stays at its inactive level.
- R5: In toggle-on-match mode the output inverts, and the flag sets, each time the counter steps onto the compare value.
- R6: In frequency mode the output inverts every N ticks, where N is compare bits 7:0. A value of 0 means 256.
- R7: In edge-aligned PWM, configuration bits 7:5 give the width w: codes 0 to 3 mean 8 to 11 bits and code 4 means 16 bits. Each 2^w-tick window of the counter's low w bits holds exactly C active ticks, where C is the compare value, and C of 2^w or more gives a fully active output.
- R8: Configuration bit 8 selects center-aligned PWM. An even C still gives C active ticks per 2^w window, placed symmetrically about the window wrap.
- R9: In PWM mode a compare write goes to a shadow register. The active compare value, which reads back at address 5+2n, takes the shadow only when the low w counter bits wrap.
- R10: Configuration bit 9 inverts the output. In the off, capture and software-timer modes the output sits at its inactive level, which is the value of bit 9.
- R11: With control bit 2 set, kill_i[control bit 3] high forces every PWM channel output to its inactive level from the next clock, for as long as it stays high. The kill input that is not selected has no effect.
- R12: Address 2 reads the flags, bit n for channel n. Writing 1 to a bit clears that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register address |
| wdata_i | input | CW | Write data |
| rdata_o | output | CW | Read data for addr_i |
| ext_clk_i | input | 1 | External timebase source |
| kill_i | input | 2 | Kill inputs; one is selected |
| cex_i | input | NCH | Channel capture inputs |
| cex_o | output | NCH | Channel outputs |
| flag_o | output | NCH | Channel event flags |

## Verification
The bench counts ticks across exact write-to-write windows, with and without the divisor and from the external source, and drives the counter through its 0xFFFF wrap. A design with an off-by-one divisor or a bad wrap shows up as a wrong counter value. Capture goes through every edge selection while the counter is stopped, so a capture on the wrong edge leaves a visibly wrong register value or a stray flag. The PWM duty is measured over whole windows at several widths, in both alignments and with inversion, so a comparison that is off by one or folded wrongly changes the count of active cycles. The compare register is read back before and after a wrap, which exposes a shadow load that happens early. The kill test checks the output one cycle after assertion, with the unselected kill input also raised.

// File: rtl/pca_pkg.sv
package pca_pkg;
  typedef enum logic [2:0] {
    M_OFF = 3'd0,
    M_CAP = 3'd1,
    M_SWT = 3'd2,
    M_HSO = 3'd3,
    M_FRQ = 3'd4,
    M_PWM = 3'd5
  } ch_mode_e;

  typedef struct packed {
    logic       inv;
    logic       center;
    logic [2:0] width;
    logic [1:0] edge_sel;
    ch_mode_e   mode;
  } ch_cfg_t;

  localparam int A_CTRL  = 0;
  localparam int A_CNT   = 1;
  localparam int A_FLAG  = 2;
  localparam int CH_BASE = 4;
endpackage

// File: rtl/pca_edge_sync.sv
module pca_edge_sync #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic qd_o
);
  logic [SYNC:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC-1:0], d_i};
  end

  assign q_o  = sh_q[SYNC-1];
  assign qd_o = sh_q[SYNC];
endmodule

// File: rtl/pca_timebase.sv
module pca_timebase #(
  parameter int CW   = 16,
  parameter int DIVW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            ext_sel_i,
  input  logic            ext_clk_i,
  input  logic [DIVW-1:0] div_i,
  input  logic            cnt_we_i,
  input  logic [CW-1:0]   cnt_wd_i,
  output logic [CW-1:0]   cnt_o,
  output logic            tick_o,
  output logic            upd_o
);
  logic            ext_q, ext_qd, src_evt;
  logic [DIVW-1:0] div_cnt_q;
  logic [CW-1:0]   cnt_q;
  logic            upd_q;

  pca_edge_sync #(.SYNC(2)) u_ext (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_clk_i),
    .q_o   (ext_q),
    .qd_o  (ext_qd)
  );

  assign src_evt = ext_sel_i ? (ext_q & ~ext_qd) : 1'b1;
  assign tick_o  = run_i && src_evt && (div_cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt_q <= '0;
      cnt_q     <= '0;
      upd_q     <= 1'b0;
    end else begin
      if (!run_i)       div_cnt_q <= '0;
      else if (src_evt) div_cnt_q <= (div_cnt_q == div_i) ? '0 : div_cnt_q + 1'b1;
      if (cnt_we_i)     cnt_q <= cnt_wd_i;
      else if (tick_o)  cnt_q <= cnt_q + 1'b1;
      upd_q <= tick_o && !cnt_we_i;
    end
  end

  assign cnt_o = cnt_q;
  assign upd_o = upd_q;
endmodule

// File: rtl/pca_channel.sv
module pca_channel
  import pca_pkg::*;
#(
  parameter int CW = 16,
  parameter int FW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ch_cfg_t       cfg_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          tick_i,
  input  logic          upd_i,
  input  logic          cmp_we_i,
  input  logic [CW-1:0] cmp_wd_i,
  input  logic          cex_i,
  input  logic          kill_i,
  output logic [CW-1:0] cmp_o,
  output logic          cex_o,
  output logic          evt_o
);
  logic          in_q, in_qd, rise, fall;
  logic [CW-1:0] cmp_q, shd_q, mask, half, pos, lowp, tri_v;
  logic [CW:0]   tri2;
  logic [FW-1:0] fcnt_q, lim;
  logic          is_pwm, is_hso, is_frq, wrap, cap_evt, match, frq_hit;
  logic          tgl_q, raw, cex_q;

  pca_edge_sync #(.SYNC(2)) u_in (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cex_i),
    .q_o   (in_q),
    .qd_o  (in_qd)
  );

  assign rise   = in_q & ~in_qd;
  assign fall   = ~in_q & in_qd;
  assign is_pwm = (cfg_i.mode == M_PWM);
  assign is_hso = (cfg_i.mode == M_HSO);
  assign is_frq = (cfg_i.mode == M_FRQ);

  // window mask; width codes above 3 use the full counter
  assign mask = (cfg_i.width < 3'd4) ? CW'((1 << (8 + int'(cfg_i.width))) - 1) : '1;
  assign pos  = cnt_i & mask;
  assign wrap = tick_i && (pos == mask);

  // center-aligned: fold the window into a triangle
  assign half  = mask >> 1;
  assign lowp  = pos & half;
  assign tri_v = ((pos & ~half) == '0) ? lowp : (half - lowp);
  assign tri2  = {1'b0, tri_v} << 1;

  assign cap_evt = (cfg_i.mode == M_CAP) &&
                   ((cfg_i.edge_sel[0] && rise) || (cfg_i.edge_sel[1] && fall));
  assign match   = upd_i && (cnt_i == cmp_q);
  assign lim     = cmp_q[FW-1:0] - 1'b1;
  assign frq_hit = is_frq && tick_i && (fcnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
      shd_q <= '0;
    end else begin
      if (cmp_we_i) shd_q <= cmp_wd_i;
      if (cap_evt)                     cmp_q <= cnt_i;
      else if (cmp_we_i && !is_pwm)    cmp_q <= cmp_wd_i;
      else if (is_pwm && wrap)         cmp_q <= shd_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q <= '0;
      tgl_q  <= 1'b0;
    end else begin
      if (!is_frq)     fcnt_q <= '0;
      else if (tick_i) fcnt_q <= (fcnt_q == lim) ? '0 : fcnt_q + 1'b1;
      if (!(is_hso || is_frq))             tgl_q <= 1'b0;
      else if ((is_hso && match) || frq_hit) tgl_q <= ~tgl_q;
    end
  end

  always_comb begin
    unique case (cfg_i.mode)
      M_PWM:        raw = cfg_i.center ? (tri2 < {1'b0, cmp_q}) : (pos < cmp_q);
      M_HSO, M_FRQ: raw = tgl_q;
      default:      raw = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cex_q <= 1'b0;
    else if (kill_i && is_pwm) cex_q <= cfg_i.inv;
    else                       cex_q <= raw ^ cfg_i.inv;
  end

  assign cmp_o = cmp_q;
  assign cex_o = cex_q;
  assign evt_o = cap_evt || (match && (is_hso || cfg_i.mode == M_SWT));
endmodule

// File: rtl/pca_top.sv
module pca_top
  import pca_pkg::*;
#(
  parameter int NCH  = 6,
  parameter int CW   = 16,
  parameter int DIVW = 8,
  parameter int AW   = $clog2(CH_BASE + 2 * NCH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [CW-1:0]   wdata_i,
  output logic [CW-1:0]   rdata_o,
  input  logic            ext_clk_i,
  input  logic [1:0]      kill_i,
  input  logic [NCH-1:0]  cex_i,
  output logic [NCH-1:0]  cex_o,
  output logic [NCH-1:0]  flag_o
);
  localparam int CFGW = $bits(ch_cfg_t);

  logic            run_q, ext_q, kill_en_q, kill_sel_q;
  logic [DIVW-1:0] div_q;
  logic [NCH-1:0]  flag_q, evt, pwm_vec, inv_vec, off_vec;
  logic [CW-1:0]   cnt;
  logic            tick, upd, cnt_we, kill_act;
  ch_cfg_t         cfg_q  [NCH];
  logic [CW-1:0]   cmp_rd [NCH];

  assign cnt_we   = wr_en_i && (addr_i == AW'(A_CNT));
  assign kill_act = kill_en_q && kill_i[kill_sel_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      ext_q      <= 1'b0;
      kill_en_q  <= 1'b0;
      kill_sel_q <= 1'b0;
      div_q      <= '0;
    end else if (wr_en_i && addr_i == AW'(A_CTRL)) begin
      run_q      <= wdata_i[0];
      ext_q      <= wdata_i[1];
      kill_en_q  <= wdata_i[2];
      kill_sel_q <= wdata_i[3];
      div_q      <= wdata_i[DIVW+7:8];
    end
  end

  pca_timebase #(.CW(CW), .DIVW(DIVW)) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_q),
    .ext_sel_i(ext_q),
    .ext_clk_i(ext_clk_i),
    .div_i    (div_q),
    .cnt_we_i (cnt_we),
    .cnt_wd_i (wdata_i),
    .cnt_o    (cnt),
    .tick_o   (tick),
    .upd_o    (upd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic cfg_we, cmp_we;
    assign cfg_we = wr_en_i && (addr_i == AW'(CH_BASE + 2 * i));
    assign cmp_we = wr_en_i && (addr_i == AW'(CH_BASE + 2 * i + 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cfg_q[i] <= '0;
      else if (cfg_we) cfg_q[i] <= ch_cfg_t'(wdata_i[CFGW-1:0]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[i] <= 1'b0;
      else         flag_q[i] <= evt[i] ||
                                (flag_q[i] && !(wr_en_i && addr_i == AW'(A_FLAG) && wdata_i[i]));
    end

    assign pwm_vec[i] = (cfg_q[i].mode == M_PWM);
    assign inv_vec[i] = cfg_q[i].inv;
    assign off_vec[i] = (cfg_q[i].mode == M_OFF) || (cfg_q[i].mode == M_CAP) ||
                        (cfg_q[i].mode == M_SWT);

    pca_channel #(.CW(CW), .FW(8)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cfg_i   (cfg_q[i]),
      .cnt_i   (cnt),
      .tick_i  (tick),
      .upd_i   (upd),
      .cmp_we_i(cmp_we),
      .cmp_wd_i(wdata_i),
      .cex_i   (cex_i[i]),
      .kill_i  (kill_act),
      .cmp_o   (cmp_rd[i]),
      .cex_o   (cex_o[i]),
      .evt_o   (evt[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(A_CTRL)) begin
      rdata_o[0]         = run_q;
      rdata_o[1]         = ext_q;
      rdata_o[2]         = kill_en_q;
      rdata_o[3]         = kill_sel_q;
      rdata_o[DIVW+7:8]  = div_q;
    end else if (addr_i == AW'(A_CNT)) begin
      rdata_o = cnt;
    end else if (addr_i == AW'(A_FLAG)) begin
      rdata_o[NCH-1:0] = flag_q;
    end
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == AW'(CH_BASE + 2 * i))     rdata_o[CFGW-1:0] = cfg_q[i];
      if (addr_i == AW'(CH_BASE + 2 * i + 1)) rdata_o = cmp_rd[i];
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pca_checker.sv
module pca_checker #(
  parameter int NCH = 6,
  parameter int CW  = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [CW-1:0]  cnt,
  input logic           cnt_we,
  input logic [CW-1:0]  cnt_wd,
  input logic           run,
  input logic           kill_act,
  input logic [NCH-1:0] pwm_vec,
  input logic [NCH-1:0] inv_vec,
  input logic [NCH-1:0] off_vec,
  input logic [NCH-1:0] cex_o
);
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cnt_we) |-> (cnt == $past(cnt) || cnt == $past(cnt) + CW'(1))); // R1

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(run) && !$past(cnt_we)) |-> (cnt == $past(cnt))); // R1

  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cnt_we) |-> (cnt == $past(cnt_wd))); // R1

  AST_KILL_INACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(kill_act) |-> (((cex_o ^ $past(inv_vec)) & $past(pwm_vec)) == '0)); // R11

  AST_IDLE_INACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) || (((cex_o ^ $past(inv_vec)) & $past(off_vec)) == '0)); // R10
endmodule

bind pca_top pca_checker #(.NCH(NCH), .CW(CW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cnt     (cnt),
  .cnt_we  (cnt_we),
  .cnt_wd  (wdata_i),
  .run     (run_q),
  .kill_act(kill_act),
  .pwm_vec (pwm_vec),
  .inv_vec (inv_vec),
  .off_vec (off_vec),
  .cex_o   (cex_o)
);

// File: tb/sim_pca_top.sv
module sim_pca_top;
  localparam int NCH = 6;
  localparam int CW  = 16;
  localparam int AW  = 4;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           wr_en_i = 1'b0;
  logic [AW-1:0]  addr_i = '0;
  logic [CW-1:0]  wdata_i = '0;
  logic [CW-1:0]  rdata_o;
  logic           ext_clk_i = 1'b0;
  logic [1:0]     kill_i = '0;
  logic [NCH-1:0] cex_i = '0;
  logic [NCH-1:0] cex_o, flag_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pca_top #(.NCH(NCH), .CW(CW), .DIVW(8), .AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ext_clk_i(ext_clk_i),
    .kill_i(kill_i), .cex_i(cex_i), .cex_o(cex_o), .flag_o(flag_o)
  );

  function automatic logic [CW-1:0] cfgw(int mode, int edg, int w, int ctr, int inv);
    return CW'(mode | (edg << 3) | (w << 5) | (ctr << 8) | (inv << 9));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [CW-1:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = AW'(a); wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [CW-1:0] d);
    @(negedge clk);
    addr_i = AW'(a);
    #1 d = rdata_o;
  endtask

  task automatic count_high(input int ch, input int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (cex_o[ch]) hi++;
    end
  endtask

  task automatic count_tgl(input int ch, input int n, output int t);
    logic prev;
    t = 0;
    @(negedge clk);
    prev = cex_o[ch];
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (cex_o[ch] != prev) t++;
      prev = cex_o[ch];
    end
  endtask

  task automatic t_reset();
    logic [CW-1:0] d;
    rd(1, d);
    chk("R1 reset counter", d, 0);
    chk("R10 reset outputs", cex_o, 0);
    chk("R12 reset flags", flag_o, 0);
  endtask

  task automatic t_counter();
    logic [CW-1:0] d;
    wr(1, 16'h0000);
    wr(0, 16'h0301);
    repeat (38) @(negedge clk);
    wr(0, 16'h0300);
    rd(1, d);
    chk("R2 divisor 3 over 40 clocks", d, 10);
    repeat (5) @(negedge clk);
    rd(1, d);
    chk("R1 stopped counter holds", d, 10);
    wr(1, 16'hFFFE);
    wr(0, 16'h0001);
    repeat (1) @(negedge clk);
    wr(0, 16'h0000);
    rd(1, d);
    chk("R1 wrap past 0xFFFF", d, 16'h0001);
    wr(1, 16'h0000);
    wr(0, 16'h0103);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk) ext_clk_i = 1'b1;
      @(negedge clk);
      @(negedge clk) ext_clk_i = 1'b0;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
    wr(0, 16'h0100);
    rd(1, d);
    chk("R2 external source divided by 2", d, 3);
  endtask

  task automatic t_capture();
    logic [CW-1:0] d;
    wr(4, cfgw(1, 1, 0, 0, 0));
    wr(6, cfgw(1, 3, 0, 0, 0));
    wr(1, 16'h1234);
    @(negedge clk) cex_i[0] = 1'b1;
    repeat (5) @(negedge clk);
    rd(5, d);
    chk("R3 rising capture value", d, 16'h1234);
    chk("R3 rising capture flag", flag_o[0], 1);
    wr(2, 16'h0001);
    @(negedge clk);
    chk("R12 flag cleared by write one", flag_o[0], 0);
    wr(1, 16'h2222);
    @(negedge clk) cex_i[0] = 1'b0;
    repeat (5) @(negedge clk);
    rd(5, d);
    chk("R3 unselected falling edge ignored", d, 16'h1234);
    chk("R3 unselected edge sets no flag", flag_o[0], 0);
    wr(4, cfgw(1, 2, 0, 0, 0));
    wr(1, 16'h4444);
    @(negedge clk) cex_i[0] = 1'b1;
    repeat (5) @(negedge clk);
    wr(1, 16'h5555);
    @(negedge clk) cex_i[0] = 1'b0;
    repeat (5) @(negedge clk);
    rd(5, d);
    chk("R3 falling-only capture", d, 16'h5555);
    wr(1, 16'h6666);
    @(negedge clk) cex_i[1] = 1'b1;
    repeat (5) @(negedge clk);
    rd(7, d);
    chk("R3 both-edge capture on rise", d, 16'h6666);
    wr(1, 16'h7777);
    @(negedge clk) cex_i[1] = 1'b0;
    repeat (5) @(negedge clk);
    rd(7, d);
    chk("R3 both-edge capture on fall", d, 16'h7777);
    wr(2, 16'h003F);
    wr(4, 16'h0000);
    wr(6, 16'h0000);
  endtask

  task automatic t_match();
    wr(8, cfgw(2, 0, 0, 0, 0));
    wr(9, 16'h0010);
    wr(10, cfgw(3, 0, 0, 0, 0));
    wr(11, 16'h0008);
    wr(1, 16'h0000);
    @(negedge clk);
    chk("R5 toggle output before match", cex_o[3], 0);
    chk("R4 no flag before match", flag_o[2], 0);
    wr(0, 16'h0001);
    repeat (30) @(negedge clk);
    wr(0, 16'h0000);
    repeat (3) @(negedge clk);
    chk("R4 software timer flag", flag_o[2], 1);
    chk("R4 software timer output idle", cex_o[2], 0);
    chk("R5 toggle output after match", cex_o[3], 1);
    chk("R5 toggle match flag", flag_o[3], 1);
    wr(8, 16'h0000);
    wr(10, 16'h0000);
  endtask

  task automatic t_freq();
    int t;
    wr(12, cfgw(4, 0, 0, 0, 0));
    wr(13, 16'h0005);
    wr(0, 16'h0001);
    repeat (20) @(negedge clk);
    count_tgl(4, 100, t);
    chk("R6 frequency N=5 toggles per 100", t, 20);
    wr(13, 16'h0000);
    repeat (300) @(negedge clk);
    count_tgl(4, 1024, t);
    chk("R6 frequency N=0 means 256", t, 4);
    wr(12, 16'h0000);
  endtask

  task automatic t_pwm();
    int hi;
    logic [CW-1:0] d;
    wr(14, cfgw(5, 0, 0, 0, 0));
    wr(15, 16'h0040);
    repeat (600) @(negedge clk);
    count_high(5, 256, hi);
    chk("R7 8-bit duty 0x40", hi, 64);
    wr(14, cfgw(5, 0, 1, 0, 0));
    wr(15, 16'h0100);
    repeat (1100) @(negedge clk);
    count_high(5, 512, hi);
    chk("R7 9-bit duty 0x100", hi, 256);
    wr(14, cfgw(5, 0, 3, 0, 0));
    wr(15, 16'h0300);
    repeat (4200) @(negedge clk);
    count_high(5, 2048, hi);
    chk("R7 11-bit duty 0x300", hi, 768);
    wr(14, cfgw(5, 0, 0, 1, 0));
    wr(15, 16'h0040);
    repeat (600) @(negedge clk);
    count_high(5, 256, hi);
    chk("R8 center-aligned duty 0x40", hi, 64);
    wr(14, cfgw(5, 0, 0, 0, 1));
    repeat (600) @(negedge clk);
    count_high(5, 256, hi);
    chk("R10 inverted 8-bit duty", hi, 192);
    wr(14, cfgw(5, 0, 0, 0, 0));
    wr(0, 16'h0000);
    wr(1, 16'h0010);
    wr(15, 16'h0080);
    rd(15, d);
    chk("R9 active compare unchanged before wrap", d, 16'h0040);
    wr(0, 16'h0001);
    repeat (100) @(negedge clk);
    rd(15, d);
    chk("R9 active compare unchanged mid window", d, 16'h0040);
    repeat (200) @(negedge clk);
    rd(15, d);
    chk("R9 active compare loaded at wrap", d, 16'h0080);
  endtask

  task automatic t_kill();
    wr(15, 16'h0100);
    repeat (600) @(negedge clk);
    chk("R7 full-scale output active", cex_o[5], 1);
    wr(0, 16'h0005);
    @(negedge clk) kill_i[1] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 unselected kill ignored", cex_o[5], 1);
    @(negedge clk) kill_i[0] = 1'b1;
    @(negedge clk);
    chk("R11 kill inactive next clock", cex_o[5], 0);
    repeat (10) @(negedge clk);
    chk("R11 kill held inactive", cex_o[5], 0);
    @(negedge clk) begin kill_i[0] = 1'b0; kill_i[1] = 1'b0; end
    repeat (2) @(negedge clk);
    chk("R11 output resumes after kill", cex_o[5], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_counter();
    t_capture();
    t_match();
    t_freq();
    t_pwm();
    t_kill();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule